// File: doc/BRIEF.md
# Bypassable Complex Interpolate-by-8 FIR

This block raises the sample rate of one complex (I/Q) stream by a factor of eight on a transmit path. Upstream delivers packed words, each holding an I and a Q component. The block drives them out as two separate signed lanes, one new output pair for every read strobe from the downstream converter. In filtering mode each accepted input sample feeds eight consecutive outputs. The block computes them with a polyphase structure of eight branches, each sixteen taps long. It throttles upstream with a one-cycle ready pulse, so only one input is accepted per eight reads.

A single run-time control input selects filtering or straight pass-through. In pass-through mode each read strobe moves one input word, unchanged, to the output lanes. The downstream consumer then sets the pace alone. Any change of the control input flushes the filter history and restarts the phase sequence, so that no sample from the old mode leaks into the new one. The coefficients are a fixed table that the block computes from its parameters at elaboration.

Top module: `iq_interp_fir`

## Requirements
- R1: While reset is held and in the first cycle after it, out_i and out_q are 0. After reset the block is in pass-through mode, and the delay line and phase are zero.
- R2: The input word carries I in bits 15:0 and Q in bits 31:16, both two's complement. In pass-through mode, a read strobe with s_tvalid high puts these two halves on out_i and out_q in the next cycle.
- R3: In pass-through mode, with interp_en unchanged, s_tready equals rd_strobe in every cycle.
- R4: In filtering mode, with interp_en unchanged, s_tready is high only in a cycle with rd_strobe high. It is high on the first read after a mode change and then on exactly every eighth read.
- R5: Coefficient k (k = 0..127) is h[k] = 63*(k+1) for k < 64 and h[k] = 63*(128-k) otherwise. Phase p (0..7) counts reads since the last ready read, with the ready read itself being phase 0. Output p is round(sum over m=0..15 of h[8m+p]*x[n-m] / 32768), where x[n] is the newest accepted sample and rounding adds 16384 before flooring. I and Q are filtered separately.
- R6: out_i and out_q change only in the cycle after a read strobe. Otherwise they hold, including through a mode change.
- R7: A read with s_tvalid low in a cycle where s_tready is high uses a zero sample in place of the input, in both modes.
- R8: Mode is compared against a stored mode that is reset to pass-through. In the cycle where interp_en differs from it, s_tready is low and any read strobe is ignored. The stored mode, phase and delay line are updated in that cycle, and the delay line is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interp_en | input | 1 | 1 selects 8x filtering, 0 selects pass-through |
| s_tdata | input | 32 | Packed input sample, Q in 31:16, I in 15:0 |
| s_tvalid | input | 1 | Input sample available |
| s_tready | output | 1 | Input sample taken this cycle when s_tvalid is high |
| rd_strobe | input | 1 | Consumer read strobe, one output pair per strobe |
| out_i | output | 16 | I output lane |
| out_q | output | 16 | Q output lane |

## Verification
The bench builds the block with its default parameters: 16-bit lanes, 18-bit coefficients, factor 8 and 128 taps. These are the values for which R5 spells out the coefficient formula. An impulse of full-scale I and the most negative Q value walks all 128 coefficients through both lanes. This exposes the rounding and the sign handling in every phase. Mode changes are made both at a block boundary and in the middle of an eight-read block, and reads without valid input are made in both modes.

// File: rtl/iq_interp_fir_pkg.sv
package iq_interp_fir_pkg;

    // Triangular kernel whose polyphase branches each sum to 2^frac / s * s.
    function automatic int tri_coef(int k, int n, int l, int frac);
        int s;
        s = (1 << frac) / ((n * (n + 2)) / (4 * l));
        return (k < n / 2) ? s * (k + 1) : s * (n - k);
    endfunction

endpackage

// File: rtl/fir_branch_mac.sv
module fir_branch_mac #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 18,
    parameter int FACTOR = 8,
    parameter int TAPS   = 128,
    parameter int FRAC   = 15,
    parameter int BT     = TAPS / FACTOR,
    parameter int PH_W   = $clog2(FACTOR),
    parameter int ACC_W  = DATA_W + COEF_W + $clog2(BT) + 1
) (
    input  logic [PH_W-1:0]            phase,
    input  logic [BT-1:0][DATA_W-1:0]  line,
    output logic signed [ACC_W-1:0]    acc
);
    import iq_interp_fir_pkg::*;

    logic signed [COEF_W-1:0] cbank [FACTOR][BT];

    for (genvar p = 0; p < FACTOR; p++) begin : g_phase
        for (genvar m = 0; m < BT; m++) begin : g_tap
            assign cbank[p][m] = COEF_W'(tri_coef(m * FACTOR + p, TAPS, FACTOR, FRAC));
        end
    end

    always_comb begin
        logic signed [ACC_W-1:0] xe;
        logic signed [ACC_W-1:0] ce;
        acc = '0;
        for (int m = 0; m < BT; m++) begin
            xe  = ACC_W'(signed'(line[m]));
            ce  = ACC_W'(cbank[phase][m]);
            acc = acc + xe * ce;
        end
    end
endmodule

// File: rtl/fir_round_sat.sv
module fir_round_sat #(
    parameter int DATA_W = 16,
    parameter int FRAC   = 15,
    parameter int ACC_W  = 40
) (
    input  logic signed [ACC_W-1:0]  acc,
    output logic [DATA_W-1:0]        y
);
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << (DATA_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

    logic signed [ACC_W-1:0] sh;

    always_comb begin
        sh = (acc + HALF) >>> FRAC;
        if (sh > MAXV)      y = MAXV[DATA_W-1:0];
        else if (sh < MINV) y = MINV[DATA_W-1:0];
        else                y = sh[DATA_W-1:0];
    end
endmodule

// File: rtl/iq_interp_fir.sv
module iq_interp_fir #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 18,
    parameter int FACTOR = 8,
    parameter int TAPS   = 128,
    parameter int FRAC   = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  interp_en,
    input  logic [2*DATA_W-1:0]   s_tdata,
    input  logic                  s_tvalid,
    output logic                  s_tready,
    input  logic                  rd_strobe,
    output logic [DATA_W-1:0]     out_i,
    output logic [DATA_W-1:0]     out_q
);
    localparam int BT    = TAPS / FACTOR;
    localparam int PH_W  = $clog2(FACTOR);
    localparam int ACC_W = DATA_W + COEF_W + $clog2(BT) + 1;
    localparam int LANES = 2;

    typedef struct packed {
        logic                            mode;
        logic [PH_W-1:0]                 phase;
        logic [LANES-1:0][BT-1:0][DATA_W-1:0] dl;
        logic [LANES-1:0][DATA_W-1:0]    y;
    } state_t;

    state_t st_d, st_q;

    logic                                 mode_chg;
    logic [LANES-1:0][DATA_W-1:0]         x_new;
    logic [LANES-1:0][BT-1:0][DATA_W-1:0] line;
    logic signed [ACC_W-1:0]              acc  [LANES];
    logic [LANES-1:0][DATA_W-1:0]         y_f;

    always_comb begin
        mode_chg = (interp_en != st_q.mode);
        for (int l = 0; l < LANES; l++) begin
            x_new[l] = s_tvalid ? s_tdata[l*DATA_W +: DATA_W] : '0;
            line[l]  = (st_q.phase == '0) ? {st_q.dl[l][BT-2:0], x_new[l]} : st_q.dl[l];
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        fir_branch_mac #(
            .DATA_W(DATA_W), .COEF_W(COEF_W), .FACTOR(FACTOR), .TAPS(TAPS),
            .FRAC(FRAC), .BT(BT), .PH_W(PH_W), .ACC_W(ACC_W)
        ) mac_i (
            .phase(st_q.phase),
            .line (line[l]),
            .acc  (acc[l])
        );
        fir_round_sat #(.DATA_W(DATA_W), .FRAC(FRAC), .ACC_W(ACC_W)) rs_i (
            .acc(acc[l]),
            .y  (y_f[l])
        );
    end

    always_comb begin
        st_d = st_q;
        if (mode_chg) begin
            s_tready   = 1'b0;
            st_d.mode  = interp_en;
            st_d.phase = '0;
            st_d.dl    = '0;
        end else if (st_q.mode) begin
            s_tready = rd_strobe && (st_q.phase == '0);
            if (rd_strobe) begin
                st_d.y     = y_f;
                st_d.phase = (st_q.phase == PH_W'(FACTOR - 1)) ? '0 : st_q.phase + 1'b1;
                if (st_q.phase == '0) st_d.dl = line;
            end
        end else begin
            s_tready = rd_strobe;
            if (rd_strobe) st_d.y = x_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_i = st_q.y[0];
    assign out_q = st_q.y[1];
endmodule

// File: rtl/iq_interp_fir_chk.sv
module iq_interp_fir_chk #(
    parameter int DATA_W = 16,
    parameter int FACTOR = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                interp_en,
    input logic [2*DATA_W-1:0] s_tdata,
    input logic                s_tvalid,
    input logic                s_tready,
    input logic                rd_strobe,
    input logic [DATA_W-1:0]   out_i,
    input logic [DATA_W-1:0]   out_q
);
    logic              prev_en_q;
    logic              byp_rd_q;
    logic [DATA_W-1:0] byp_i_q, byp_q_q;
    int                rd_cnt_q;
    logic              steady;

    assign steady = (interp_en == prev_en_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_en_q <= 1'b0;
            byp_rd_q  <= 1'b0;
            byp_i_q   <= '0;
            byp_q_q   <= '0;
            rd_cnt_q  <= 0;
        end else begin
            prev_en_q <= interp_en;
            byp_rd_q  <= steady && !interp_en && rd_strobe;
            byp_i_q   <= s_tvalid ? s_tdata[DATA_W-1:0] : '0;
            byp_q_q   <= s_tvalid ? s_tdata[2*DATA_W-1:DATA_W] : '0;
            if (!steady || !interp_en) rd_cnt_q <= 0;
            else if (rd_strobe)        rd_cnt_q <= (rd_cnt_q == FACTOR - 1) ? 0 : rd_cnt_q + 1;
        end
    end

    assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byp_rd_q |-> (out_i == byp_i_q && out_q == byp_q_q));   // also R7 in pass-through

    assert_bypass_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && !interp_en) |-> (s_tready == rd_strobe));

    assert_ready_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && interp_en && s_tready) |-> rd_strobe);

    assert_ready_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (steady && interp_en && rd_strobe) |-> (s_tready == (rd_cnt_q == 0)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> ($stable(out_i) && $stable(out_q)));

    assert_switch_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !steady |-> !s_tready);

    assert_switch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !steady |=> ($stable(out_i) && $stable(out_q)));
endmodule

bind iq_interp_fir iq_interp_fir_chk #(.DATA_W(DATA_W), .FACTOR(FACTOR)) chk_i (.*);

// File: tb/iq_interp_fir_tb_top.sv
module iq_interp_fir_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        interp_en = 1'b0;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic        rd_strobe = 1'b0;
    logic [15:0] out_i, out_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state, from the requirements
    bit mdl_mode = 0;
    int mdl_phase = 0;
    int mdl_i [16];
    int mdl_q [16];
    int last_i = 0, last_q = 0;

    always #2 clk = ~clk;   // 250 MHz

    iq_interp_fir dut_i (
        .clk(clk), .rst_n(rst_n), .interp_en(interp_en), .s_tdata(s_tdata),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .rd_strobe(rd_strobe),
        .out_i(out_i), .out_q(out_q)
    );

    function automatic int hcoef(int k);
        int s = 32768 / 520;
        return (k < 64) ? s * (k + 1) : s * (128 - k);
    endfunction

    function automatic int rnd(longint acc);
        longint r = (acc + 16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_model();
        mdl_phase = 0;
        for (int m = 0; m < 16; m++) begin mdl_i[m] = 0; mdl_q[m] = 0; end
    endtask

    // one consumer read; checks ready and the resulting output pair
    task automatic rd(input bit v, input logic [31:0] d, input string req);
        int xi, xq, ei, eq;
        bit exp_rdy;
        longint ai, aq;
        @(negedge clk);
        rd_strobe = 1'b1; s_tvalid = v; s_tdata = d;
        #1;
        exp_rdy = mdl_mode ? (mdl_phase == 0) : 1'b1;
        chk(mdl_mode ? "R4" : "R3", "s_tready", int'(s_tready), int'(exp_rdy));
        xi = v ? int'(signed'(d[15:0])) : 0;
        xq = v ? int'(signed'(d[31:16])) : 0;
        if (mdl_mode) begin
            if (mdl_phase == 0) begin
                for (int m = 15; m > 0; m--) begin mdl_i[m] = mdl_i[m-1]; mdl_q[m] = mdl_q[m-1]; end
                mdl_i[0] = xi; mdl_q[0] = xq;
            end
            ai = 0; aq = 0;
            for (int m = 0; m < 16; m++) begin
                ai += longint'(hcoef(8*m + mdl_phase)) * mdl_i[m];
                aq += longint'(hcoef(8*m + mdl_phase)) * mdl_q[m];
            end
            ei = rnd(ai); eq = rnd(aq);
            mdl_phase = (mdl_phase + 1) % 8;
        end else begin
            ei = xi; eq = xq;
        end
        @(posedge clk); #1;
        rd_strobe = 1'b0; s_tvalid = 1'b0;
        chk(req, "out_i", int'(signed'(out_i)), ei);
        chk(req, "out_q", int'(signed'(out_q)), eq);
        last_i = ei; last_q = eq;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk); rd_strobe = 1'b0;
            @(posedge clk); #1;
            chk("R6", "hold out_i", int'(signed'(out_i)), last_i);
            chk("R6", "hold out_q", int'(signed'(out_q)), last_q);
        end
    endtask

    task automatic set_mode(input bit en);
        @(negedge clk);
        interp_en = en; rd_strobe = 1'b1; s_tvalid = 1'b1; s_tdata = 32'h1234_5678;
        #1;
        chk("R8", "s_tready at switch", int'(s_tready), 0);
        @(posedge clk); #1;
        rd_strobe = 1'b0; s_tvalid = 1'b0;
        chk("R8", "out_i at switch", int'(signed'(out_i)), last_i);
        chk("R8", "out_q at switch", int'(signed'(out_q)), last_q);
        mdl_mode = en;
        clear_model();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "out_i in reset", int'(out_i), 0);
        chk("R1", "out_q in reset", int'(out_q), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", "out_i after reset", int'(out_i), 0);
        chk("R1", "s_tready idle", int'(s_tready), 0);
        mdl_mode = 0; clear_model(); last_i = 0; last_q = 0;
    endtask

    task automatic t_bypass();
        rd(1, 32'h8000_7FFF, "R2");
        rd(1, 32'h0001_FFFF, "R2");
        rd(1, 32'hABCD_1234, "R2");
        idle(3);
        rd(0, 32'hDEAD_BEEF, "R7");
        rd(1, 32'h7FFF_8000, "R2");
    endtask

    task automatic t_impulse();
        set_mode(1);
        rd(1, 32'h8000_7FFF, "R5");
        for (int r = 1; r < 128; r++) rd(1, 32'h0, "R5");
        idle(2);
    endtask

    task automatic t_stream();
        for (int r = 0; r < 64; r++) begin
            logic [15:0] a, b;
            a = 16'(r * 3001 - 20000);
            b = 16'(17000 - r * 777);
            rd(1, {b, a}, "R5");
        end
        rd(0, 32'hFFFF_FFFF, "R7");
        for (int r = 0; r < 7; r++) rd(1, 32'h1111_2222, "R7");
    endtask

    task automatic t_switch();
        rd(1, 32'h4000_C000, "R5");
        rd(1, 32'h0, "R5");
        rd(1, 32'h0, "R5");
        set_mode(0);
        rd(1, 32'h0002_0001, "R8");
        set_mode(1);
        for (int r = 0; r < 16; r++) rd(1, 32'h2000_E000, "R8");
        set_mode(0);
        rd(1, 32'h5555_AAAA, "R8");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_bypass();
        t_impulse();
        t_stream();
        t_switch();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule